// File: doc/BRIEF.md
# ETU Waiting-Time Counter

This unit supervises smart-card protocol timing by counting elementary time unit (ETU) ticks. Typical uses are the answer-to-reset window, the waiting time between characters and the waiting time for a block. The ETU tick is produced elsewhere and arrives here as a one-cycle strobe. A host programs three reload registers and one configuration register through a simple write port. When a counter runs out, it sets a sticky expiry flag. An interrupt line reports whether any flag is set.

The counter works in one of two ways.

- **Single mode:** one wide counter whose length is three register widths (24 bits by default).
- **Split mode:** a two-register-wide counter (channel A) and a one-register-wide counter (channel B) run independently.

Each channel has its own start rule:

- start when the host writes it;
- start on each start bit the UART detects, so the counter fires only if no character arrives within the window;
- free-run with automatic reload.

Each channel is a small state machine with three states:

- `CH_IDLE`: stopped.
- `CH_ARMED`: waiting for a start bit.
- `CH_COUNT`: counting ticks.

Transitions:

- A configuration write moves a channel from any state:
  - to `CH_IDLE` for the stop code;
  - to `CH_ARMED` for start-bit mode;
  - to `CH_COUNT`, with a load, for write-start or free-run mode.
- `CH_IDLE` goes to `CH_COUNT` when the channel's top reload byte is written in write-start mode.
- `CH_ARMED` goes to `CH_COUNT` on a start bit.
- `CH_COUNT` reloads in place when its restart event occurs.
- On the final tick, `CH_COUNT` expires:
  - it stays in `CH_COUNT` with a reload in free-run mode;
  - it goes to `CH_ARMED` in start-bit mode;
  - it goes to `CH_IDLE` in write-start mode.

Top module: `etu_wait_timer`

## Requirements
- R1: After reset, `flag_a`, `flag_b` and `irq` are 0. Both channels are in `CH_IDLE`, and the configuration register holds single mode with both run codes set to stop.
- R2: The write port uses the following map.
  - Address 0 is reload byte 0, the least significant byte.
  - Address 1 is reload byte 1.
  - Address 2 is reload byte 2.
  - Address 3 is the configuration register:
    - bits [1:0] are the run code of channel A;
    - bits [3:2] are the run code of channel B;
    - bit 4 selects split mode when 1.
  - The run codes are 00 stop, 01 start on write, 10 start on start bit, and 11 free-run with reload.
- R3: In single mode, channel A loads {byte2, byte1, byte0}. It sets `flag_a` on the N-th counted tick after it starts. Channel B stays stopped whatever bits [3:2] hold, and `flag_b` never sets.
- R4: In split mode, channel A loads {byte1, byte0} and channel B loads byte2. The two count independently and set `flag_a` and `flag_b` respectively.
- R5: In start-on-write mode, the configuration write loads the channel and starts it. Each later write of the channel's top byte reloads it and restarts it from the new value. The top byte is address 1 for channel A in split mode and address 2 otherwise. Writing any other byte does not start the channel.
- R6: In start-bit mode, the configuration write only arms the channel, and ticks are ignored until `start_bit` pulses. Every start bit reloads the channel and restarts it. After expiry the channel waits for the next start bit.
- R7: In free-run mode, a channel reloads at expiry and keeps counting, so it expires every N ticks.
- R8: In start-on-write mode, a channel stops after it expires. Further ticks set no flag until it is restarted.
- R9: A flag stays at 1 until a one-cycle `stat_rd` pulse clears both flags. An expiry in the same cycle as `stat_rd` leaves its flag set.
- R10: A configuration write whose run codes are both 00 halts both channels at once, and no flag is set.
- R11: A reload value of zero counts the full range: 2^24 ticks in single mode, 2^16 ticks for split channel A, and 2^8 ticks for channel B.
- R12: `irq` is 1 exactly while `flag_a` or `flag_b` is 1.
- R13: A tick in the same cycle as a load, reload or restart is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DW | Register write data |
| etu_tick | input | 1 | One-cycle strobe per ETU |
| start_bit | input | 1 | One-cycle pulse when the UART detects a start bit |
| stat_rd | input | 1 | Status read strobe; clears both flags |
| flag_a | output | 1 | Sticky expiry flag of channel A |
| flag_b | output | 1 | Sticky expiry flag of channel B |
| irq | output | 1 | Interrupt, the OR of the two flags |

## Verification
The bench builds the block with its default DW of 8, the width at which real reload windows are programmed. At that width the zero-as-maximum rule can be checked to its exact edge for channel B (256 ticks) and for split channel A (65,536 ticks), with one tick before the edge and one tick at it. The 2^24 single-mode window is out of reach in run time, so in single mode only short counts and a 256-tick count that carries across byte 1 are checked.

// File: rtl/etu_wait_pkg.sv
package etu_wait_pkg;

    typedef enum logic [1:0] {
        RUN_OFF      = 2'b00,
        RUN_ON_WRITE = 2'b01,
        RUN_ON_SBIT  = 2'b10,
        RUN_FREE     = 2'b11
    } run_mode_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'b00,
        CH_ARMED = 2'b01,
        CH_COUNT = 2'b10
    } ch_state_e;

    localparam logic [1:0] CFG_ADDR  = 2'd3;
    localparam int         SPLIT_BIT = 4;

endpackage

// File: rtl/wt_regs.sv
module wt_regs
    import etu_wait_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DW-1:0]       wr_data,
    output logic [2:0][DW-1:0]  rl_next,
    output logic                split_q,
    output logic                split_next,
    output logic                cfg_wr,
    output logic                top_wr_a,
    output logic                top_wr_b,
    output run_mode_e           mode_a,
    output run_mode_e           mode_b
);

    logic [2:0][DW-1:0] rl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rl_q    <= '0;
            split_q <= 1'b0;
        end else begin
            rl_q    <= rl_next;
            split_q <= split_next;
        end
    end

    // Written byte is forwarded so a load in the same cycle sees it.
    always_comb begin
        for (int i = 0; i < 3; i++) begin
            rl_next[i] = (wr_en && wr_addr == 2'(i)) ? wr_data : rl_q[i];
        end
    end

    assign cfg_wr     = wr_en && (wr_addr == CFG_ADDR);
    assign split_next = cfg_wr ? wr_data[SPLIT_BIT] : split_q;
    assign mode_a     = run_mode_e'(wr_data[1:0]);
    assign mode_b     = wr_data[SPLIT_BIT] ? run_mode_e'(wr_data[3:2]) : RUN_OFF;
    assign top_wr_a   = wr_en && (wr_addr == (split_q ? 2'd1 : 2'd2));
    assign top_wr_b   = wr_en && split_q && (wr_addr == 2'd2);

endmodule

// File: rtl/wt_channel.sv
module wt_channel
    import etu_wait_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  run_mode_e     mode_in,
    input  logic          restart,
    input  logic          start_bit,
    input  logic          tick,
    input  logic [W-1:0]  load_val,
    output logic          expire
);

    ch_state_e        st_q, st_d;
    run_mode_e        mode_q, mode_d;
    logic [W-1:0]     cnt_q, cnt_d;
    logic             reload_evt;
    logic             last;

    assign last       = (cnt_q == W'(1));
    assign reload_evt = (mode_q == RUN_ON_SBIT  && start_bit) ||
                        (mode_q == RUN_ON_WRITE && restart);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= CH_IDLE;
            mode_q <= RUN_OFF;
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        mode_d = mode_q;
        cnt_d  = cnt_q;
        if (cfg_wr) begin
            mode_d = mode_in;
            unique case (mode_in)
                RUN_OFF:     st_d = CH_IDLE;
                RUN_ON_SBIT: st_d = CH_ARMED;
                default: begin
                    st_d  = CH_COUNT;
                    cnt_d = load_val;
                end
            endcase
        end else begin
            unique case (st_q)
                CH_IDLE: begin
                    if (mode_q == RUN_ON_WRITE && restart) begin
                        st_d  = CH_COUNT;
                        cnt_d = load_val;
                    end
                end
                CH_ARMED: begin
                    if (start_bit) begin
                        st_d  = CH_COUNT;
                        cnt_d = load_val;
                    end
                end
                CH_COUNT: begin
                    if (reload_evt) begin
                        cnt_d = load_val;
                    end else if (tick) begin
                        if (last) begin
                            if (mode_q == RUN_FREE)         cnt_d = load_val;
                            else if (mode_q == RUN_ON_SBIT) st_d  = CH_ARMED;
                            else                            st_d  = CH_IDLE;
                        end else begin
                            cnt_d = cnt_q - W'(1);
                        end
                    end
                end
                default: st_d = CH_IDLE;
            endcase
        end
    end

    always_comb begin
        expire = (st_q == CH_COUNT) && tick && last && !cfg_wr && !reload_evt;
    end

endmodule

// File: rtl/etu_wait_timer.sv
module etu_wait_timer
    import etu_wait_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          etu_tick,
    input  logic          start_bit,
    input  logic          stat_rd,
    output logic          flag_a,
    output logic          flag_b,
    output logic          irq
);

    localparam int LO_W  = 2 * DW;
    localparam int TOT_W = 3 * DW;

    logic [2:0][DW-1:0] rl_next;
    logic               split_q, split_next, cfg_wr, top_wr_a, top_wr_b;
    run_mode_e          mode_a, mode_b;
    logic [LO_W-1:0]    lo_val;
    logic [TOT_W-1:0]   load_a;
    logic               exp_a, exp_b;

    wt_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rl_next    (rl_next),
        .split_q    (split_q),
        .split_next (split_next),
        .cfg_wr     (cfg_wr),
        .top_wr_a   (top_wr_a),
        .top_wr_b   (top_wr_b),
        .mode_a     (mode_a),
        .mode_b     (mode_b)
    );

    // Split mode: a zero value means the full 16-bit range.
    assign lo_val = {rl_next[1], rl_next[0]};
    assign load_a = split_next
                  ? ((lo_val == '0) ? (TOT_W'(1) << LO_W) : TOT_W'(lo_val))
                  : {rl_next[2], rl_next[1], rl_next[0]};

    wt_channel #(.W(TOT_W)) u_chan_a (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .mode_in   (mode_a),
        .restart   (top_wr_a),
        .start_bit (start_bit),
        .tick      (etu_tick),
        .load_val  (load_a),
        .expire    (exp_a)
    );

    wt_channel #(.W(DW)) u_chan_b (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .mode_in   (mode_b),
        .restart   (top_wr_b),
        .start_bit (start_bit),
        .tick      (etu_tick),
        .load_val  (rl_next[2]),
        .expire    (exp_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_a <= 1'b0;
            flag_b <= 1'b0;
        end else begin
            flag_a <= exp_a || (flag_a && !stat_rd);
            flag_b <= exp_b || (flag_b && !stat_rd);
        end
    end

    assign irq = flag_a || flag_b;

endmodule

// File: rtl/etu_wait_timer_chk.sv
module etu_wait_timer_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          stat_rd,
    input logic          flag_a,
    input logic          flag_b,
    input logic          exp_a,
    input logic          exp_b,
    input logic          split_q
);

    initial begin
        a_r2_width_fits_cfg: assert (DW >= 5);
    end

    a_r9_flag_a_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_a && !$past(flag_a)) |-> $past(exp_a));

    a_r9_flag_b_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_b && !$past(flag_b)) |-> $past(exp_b));

    a_r9_expiry_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
        exp_a |=> flag_a);

    a_r9_expiry_sets_b: assert property (@(posedge clk) disable iff (!rst_n)
        exp_b |=> flag_b);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !exp_a && !exp_b) |=> (!flag_a && !flag_b));

    a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3 && wr_data[3:0] == 4'd0) |=> (!exp_a && !exp_b));

    a_r3_b_silent_single: assert property (@(posedge clk) disable iff (!rst_n)
        !split_q |-> !exp_b);

endmodule

bind etu_wait_timer etu_wait_timer_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .stat_rd (stat_rd),
    .flag_a  (flag_a),
    .flag_b  (flag_b),
    .exp_a   (exp_a),
    .exp_b   (exp_b),
    .split_q (split_q)
);

// File: tb/etu_wait_timer_bench.sv
module etu_wait_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          etu_tick = 1'b0;
    logic          start_bit = 1'b0;
    logic          stat_rd = 1'b0;
    logic          flag_a, flag_b, irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    etu_wait_timer #(.DW(DW)) u_etu_wait_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .etu_tick  (etu_tick),
        .start_bit (start_bit),
        .stat_rd   (stat_rd),
        .flag_a    (flag_a),
        .flag_b    (flag_b),
        .irq       (irq)
    );

    typedef struct packed {
        logic        split;
        logic [7:0]  r0;
        logic [7:0]  r1;
        logic [7:0]  r2;
        logic [31:0] ticks;
        logic        ea;
        logic        eb;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd3, 8'd0, 8'd0, 32'd2,   1'b0, 1'b0},
        '{1'b0, 8'd3, 8'd0, 8'd0, 32'd3,   1'b1, 1'b0},
        '{1'b0, 8'd0, 8'd1, 8'd0, 32'd255, 1'b0, 1'b0},
        '{1'b0, 8'd0, 8'd1, 8'd0, 32'd256, 1'b1, 1'b0},
        '{1'b1, 8'd5, 8'd0, 8'd3, 32'd3,   1'b0, 1'b1},
        '{1'b1, 8'd5, 8'd0, 8'd3, 32'd5,   1'b1, 1'b1},
        '{1'b1, 8'd2, 8'd0, 8'd9, 32'd2,   1'b1, 1'b0},
        '{1'b0, 8'd4, 8'd0, 8'd0, 32'd4,   1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            etu_tick = 1'b1;
        end
        @(negedge clk);
        etu_tick = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic pulse_sbit();
        @(negedge clk);
        start_bit = 1'b1;
        @(negedge clk);
        start_bit = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 flag_a", flag_a, 1'b0);
        chk("R1 flag_b", flag_b, 1'b0);
        chk("R1 irq", irq, 1'b0);
        rst_n = 1'b1;
        ticks(5);
        chk("R1 idle after reset", irq, 1'b0);

        // Table: R2, R3, R4 with both channels in write-start mode
        for (int v = 0; v < NV; v++) begin
            wr(2'd3, 8'h00);
            clear_flags();
            wr(2'd0, VECS[v].r0);
            wr(2'd1, VECS[v].r1);
            wr(2'd2, VECS[v].r2);
            wr(2'd3, {3'b000, VECS[v].split, 4'b0101});
            ticks(int'(VECS[v].ticks));
            if (VECS[v].split) begin
                chk("R4 vec flag_a", flag_a, VECS[v].ea);
                chk("R4 vec flag_b", flag_b, VECS[v].eb);
            end else begin
                chk("R3 vec flag_a", flag_a, VECS[v].ea);
                chk("R3 vec flag_b", flag_b, VECS[v].eb);
            end
        end

        // R12 and R9: irq follows flags, read clears
        chk("R12 irq set", irq, 1'b1);
        clear_flags();
        chk("R9 read clears", flag_a, 1'b0);
        chk("R12 irq clear", irq, 1'b0);

        // R8: write-start stops after expiry
        wr(2'd3, 8'h00);
        wr(2'd0, 8'd3); wr(2'd1, 8'd0); wr(2'd2, 8'd0);
        wr(2'd3, 8'h01);
        ticks(3);
        chk("R8 first expiry", flag_a, 1'b1);
        clear_flags();
        ticks(20);
        chk("R8 stays stopped", flag_a, 1'b0);

        // R5: low byte does not start; top byte restarts
        wr(2'd0, 8'd10);
        ticks(5);
        chk("R5 low byte no start", flag_a, 1'b0);
        wr(2'd2, 8'd0);
        ticks(9);
        chk("R5 before edge", flag_a, 1'b0);
        ticks(1);
        chk("R5 at edge", flag_a, 1'b1);
        clear_flags();
        wr(2'd2, 8'd0);
        ticks(6);
        wr(2'd2, 8'd0);
        ticks(9);
        chk("R5 mid restart", flag_a, 1'b0);
        ticks(1);
        chk("R5 mid restart edge", flag_a, 1'b1);

        // R6: start-bit mode, split channel A
        wr(2'd3, 8'h00);
        clear_flags();
        wr(2'd0, 8'd4); wr(2'd1, 8'd0);
        wr(2'd3, 8'h12);
        ticks(10);
        chk("R6 armed ignores ticks", flag_a, 1'b0);
        pulse_sbit();
        ticks(3);
        pulse_sbit();
        ticks(3);
        chk("R6 start bit reloads", flag_a, 1'b0);
        ticks(1);
        chk("R6 expiry", flag_a, 1'b1);
        clear_flags();
        ticks(10);
        chk("R6 waits again", flag_a, 1'b0);
        pulse_sbit();
        ticks(4);
        chk("R6 second window", flag_a, 1'b1);

        // R7: free-run on channel B
        wr(2'd3, 8'h00);
        clear_flags();
        wr(2'd2, 8'd3);
        wr(2'd3, 8'h1C);
        ticks(3);
        chk("R7 first period", flag_b, 1'b1);
        clear_flags();
        ticks(2);
        chk("R7 mid period", flag_b, 1'b0);
        ticks(1);
        chk("R7 second period", flag_b, 1'b1);

        // R10: stop code halts both silently
        wr(2'd3, 8'h00);
        clear_flags();
        wr(2'd0, 8'd5); wr(2'd1, 8'd0); wr(2'd2, 8'd6);
        wr(2'd3, 8'h15);
        ticks(4);
        wr(2'd3, 8'h10);
        ticks(10);
        chk("R10 flag_a quiet", flag_a, 1'b0);
        chk("R10 flag_b quiet", flag_b, 1'b0);

        // R13: tick during the load cycle is not counted
        wr(2'd3, 8'h00);
        clear_flags();
        wr(2'd0, 8'd2); wr(2'd1, 8'd0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h11; etu_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; etu_tick = 1'b0;
        ticks(1);
        chk("R13 load tick skipped", flag_a, 1'b0);
        ticks(1);
        chk("R13 expiry", flag_a, 1'b1);

        // R9: set wins over a simultaneous read
        clear_flags();
        wr(2'd0, 8'd1);
        wr(2'd3, 8'h11);
        @(negedge clk);
        etu_tick = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        etu_tick = 1'b0; stat_rd = 1'b0;
        chk("R9 set wins", flag_a, 1'b1);

        // R11: zero means full range in split mode
        wr(2'd3, 8'h00);
        clear_flags();
        wr(2'd0, 8'd0); wr(2'd1, 8'd0); wr(2'd2, 8'd0);
        wr(2'd3, 8'h15);
        ticks(255);
        chk("R11 B before 256", flag_b, 1'b0);
        ticks(1);
        chk("R11 B at 256", flag_b, 1'b1);
        chk("R11 A not yet", flag_a, 1'b0);
        clear_flags();
        ticks(65279);
        chk("R11 A before 65536", flag_a, 1'b0);
        ticks(1);
        chk("R11 A at 65536", flag_a, 1'b1);

        finish_run();
    end

endmodule